// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block keeps the time of day as four byte-wide registers: seconds, minutes, hours and day-of-week. A one-cycle pulse on a 1 Hz tick input starts an update. An update-in-progress window of fixed length follows, and the increment lands on the last cycle of that window. Two control bits set the storage format of every field. One picks BCD or plain binary, and the other picks a 24-hour clock or a 12-hour clock with the PM indicator in the top bit of the hours byte. A third control bit holds the counters so that software can load a new time without a tick landing in the middle of the load.

An alarm is held as three bytes, one each for seconds, minutes and hours, interleaved with the time fields in the address space. After each increment the new time is compared with the alarm. When all three fields agree, a sticky flag is set. An alarm byte whose two top bits are both 1 matches any value. Software reads and writes the registers through a small byte-wide bus: a write strobe, an address and write data, with read data returned combinationally for the current address.

Top module: `tod_clock`

## Requirements
- R1: After reset, seconds, minutes, hours and the three alarm bytes read 0x00, day-of-week reads 0x01, the control byte at 0x0B reads 0x02 (24-hour, BCD, not held), and the bytes at 0x0A and 0x0C read 0x00. Both output flags are low.
- R2: Addresses are fixed: seconds 0x0, alarm seconds 0x1, minutes 0x2, alarm minutes 0x3, hours 0x4, alarm hours 0x5, day-of-week 0x6, status 0xA, control 0xB, alarm status 0xC. A write to a time field keeps only that field's significant bits for the current mode. Seconds and minutes keep 0x7F in BCD and 0x3F in binary. Hours keep 0x3F in 24-hour BCD, 0x1F in 24-hour binary, 0x9F in 12-hour BCD and 0x8F in 12-hour binary. Day-of-week keeps 0x07. Alarm bytes are stored whole.
- R3: In control byte 0x0B, bit 2 = 1 selects binary and bit 2 = 0 selects BCD. Seconds count 0 to 59 and wrap to 0. Minutes advance only on that wrap, and wrap from 59 to 0 in the same way.
- R4: With bit 1 of 0x0B set (24-hour), hours advance on a minutes wrap from 0 to 23. The step from 23 goes to 0 and advances day-of-week.
- R5: With bit 1 of 0x0B clear (12-hour), hours run from 1 to 12 with bit 7 = 1 meaning PM. The step from 11 goes to 12 and inverts bit 7, and the step from 12 goes to 1 with bit 7 kept. Day-of-week advances only on the step from 11 PM to 12 AM.
- R6: Day-of-week runs from 1 to 7, and 7 steps to 1.
- R7: While bit 7 of 0x0B is 1, ticks do not change the time. Writes still take effect on the next clock.
- R8: An accepted tick drives bit 7 of 0x0A and the `update_busy` output high for exactly UIP_CYCLES cycles. The time changes on the clock edge that ends the window. Ticks that arrive during the window are dropped.
- R9: When the seconds, minutes and hours produced by an increment each equal their alarm byte, or that alarm byte has bits 7:6 = 11, `alarm_flag` and bit 7 of 0xC are set. They stay set until software writes any value to 0xC.
- R10: A software write that makes the time equal the alarm does not set the alarm flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| alarm_flag | output | 1 | Sticky alarm-match flag |
| update_busy | output | 1 | Update-in-progress window |

## Verification
The bench overrides UIP_CYCLES to 3, which keeps each tick short enough to sweep all four format combinations through every hour boundary. Within each combination the bench also steps past two full minute wraps from midnight. Expected bytes come from a seconds-of-day count that the bench re-encodes into BCD or binary and into 12- or 24-hour form. Separate directed sequences cover the busy window, the hold bit, the wildcard alarm bytes and write-only matches.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int A_SEC  = 'h0;
    localparam int A_ASEC = 'h1;
    localparam int A_MIN  = 'h2;
    localparam int A_AMIN = 'h3;
    localparam int A_HR   = 'h4;
    localparam int A_AHR  = 'h5;
    localparam int A_DOW  = 'h6;
    localparam int A_STAT = 'hA;
    localparam int A_CTRL = 'hB;
    localparam int A_ALST = 'hC;

    localparam int CTRL_HOLD_BIT = 7;
    localparam int CTRL_BIN_BIT  = 2;
    localparam int CTRL_H24_BIT  = 1;
    localparam int PM_BIT        = 7;

    typedef enum logic [1:0] {F_SEC, F_MIN, F_HR, F_DOW} field_e;

    typedef struct packed {
        logic hold;
        logic binary;
        logic hr24;
    } mode_t;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hr;
        logic [7:0] dow;
    } tod_t;

    function automatic logic [7:0] to_num(input logic [7:0] v, input logic bin);
        if (bin) return v;
        return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
    endfunction

    function automatic logic [7:0] to_code(input logic [7:0] n, input logic bin);
        if (bin) return n;
        return {4'(n / 8'd10), 4'(n % 8'd10)};
    endfunction

    function automatic logic [7:0] hour_mask(input logic bin, input logic h24);
        if (h24) return bin ? 8'h1F : 8'h3F;
        return bin ? 8'h8F : 8'h9F;
    endfunction

    function automatic logic [7:0] field_mask(input field_e f, input mode_t m);
        case (f)
            F_SEC, F_MIN: return m.binary ? 8'h3F : 8'h7F;
            F_HR:         return hour_mask(m.binary, m.hr24);
            default:      return 8'h07;
        endcase
    endfunction

endpackage

// File: rtl/tod_wrap_step.sv
module tod_wrap_step
    import tod_pkg::*;
#(
    parameter int LIMIT = 60
) (
    input  logic [7:0] cur_i,
    input  logic       binary_i,
    input  logic       carry_i,
    output logic [7:0] next_o,
    output logic       carry_o
);
    localparam logic [7:0] TOP = 8'(LIMIT - 1);

    logic [7:0] num;

    always_comb begin
        num     = to_num(cur_i, binary_i);
        next_o  = cur_i;
        carry_o = 1'b0;
        if (carry_i) begin
            if (num >= TOP) begin
                next_o  = to_code(8'd0, binary_i);
                carry_o = 1'b1;
            end else begin
                next_o  = to_code(num + 8'd1, binary_i);
            end
        end
    end

    // R3: a stepped field always lands inside 0..LIMIT-1
    always_comb begin
        if (carry_i) begin
            assert_wrap_range_R3: assert (to_num(next_o, binary_i) < 8'(LIMIT));
        end
    end

endmodule

// File: rtl/tod_hour_step.sv
module tod_hour_step
    import tod_pkg::*;
(
    input  logic [7:0] cur_i,
    input  logic       binary_i,
    input  logic       hr24_i,
    input  logic       carry_i,
    output logic [7:0] next_o,
    output logic       day_o
);
    logic [7:0] num;
    logic       pm;

    always_comb begin
        num    = to_num(cur_i & hour_mask(binary_i, 1'b1) & 8'h7F, binary_i);
        pm     = cur_i[PM_BIT];
        next_o = cur_i;
        day_o  = 1'b0;
        if (carry_i) begin
            if (hr24_i) begin
                if (num >= 8'd23) begin
                    next_o = to_code(8'd0, binary_i);
                    day_o  = 1'b1;
                end else begin
                    next_o = to_code(num + 8'd1, binary_i);
                end
            end else begin
                if (num == 8'd11) begin
                    next_o = {~pm, to_code(8'd12, binary_i)[6:0]};
                    day_o  = pm;
                end else if (num >= 8'd12) begin
                    next_o = {pm, to_code(8'd1, binary_i)[6:0]};
                end else begin
                    next_o = {pm, to_code(num + 8'd1, binary_i)[6:0]};
                end
            end
        end
    end

    // R5: a 12-hour step lands in 1..12
    always_comb begin
        if (carry_i && !hr24_i) begin
            assert_hr12_range_R5: assert (
                to_num({1'b0, next_o[6:0]}, binary_i) >= 8'd1 &&
                to_num({1'b0, next_o[6:0]}, binary_i) <= 8'd12);
        end
    end

endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match #(
    parameter int FIELDS = 3
) (
    input  logic [FIELDS-1:0][7:0] now_i,
    input  logic [FIELDS-1:0][7:0] alm_i,
    output logic                   hit_o
);
    logic [FIELDS-1:0] eq;
    logic [FIELDS-1:0] wild;

    for (genvar i = 0; i < FIELDS; i++) begin : g_field
        assign wild[i] = (alm_i[i][7:6] == 2'b11);
        assign eq[i]   = wild[i] || (alm_i[i] == now_i[i]);
    end

    assign hit_o = &eq;

    // R9: all-wildcard alarm matches any time
    always_comb begin
        if (&wild) begin
            assert_wild_hit_R9: assert (hit_o);
        end
    end

endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int UIP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              alarm_flag,
    output logic              update_busy
);
    localparam int CNT_W = $clog2(UIP_CYCLES + 1);
    localparam int WRAPS = 2;

    mode_t              mode_q;
    tod_t               now_q;
    tod_t               nxt;
    logic [7:0]         asec_q, amin_q, ahr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               flag_q;
    logic               uip, accept, commit, hit, day_cy;
    logic [WRAPS:0]     cin;
    logic [7:0]         wcur [WRAPS];
    logic [7:0]         wnxt [WRAPS];
    logic [7:0]         hr_nxt;

    assign uip    = (cnt_q != '0);
    assign accept = tick_1hz && !uip && !mode_q.hold;
    assign commit = (cnt_q == CNT_W'(1)) && !mode_q.hold;

    // seconds and minutes share one carry chain
    assign cin[0]  = 1'b1;
    assign wcur[0] = now_q.sec;
    assign wcur[1] = now_q.min;

    for (genvar i = 0; i < WRAPS; i++) begin : g_wrap
        tod_wrap_step #(.LIMIT(60)) u_step (
            .cur_i    (wcur[i]),
            .binary_i (mode_q.binary),
            .carry_i  (cin[i]),
            .next_o   (wnxt[i]),
            .carry_o  (cin[i+1])
        );
    end

    tod_hour_step u_hour (
        .cur_i    (now_q.hr),
        .binary_i (mode_q.binary),
        .hr24_i   (mode_q.hr24),
        .carry_i  (cin[WRAPS]),
        .next_o   (hr_nxt),
        .day_o    (day_cy)
    );

    always_comb begin
        nxt.sec = wnxt[0];
        nxt.min = wnxt[1];
        nxt.hr  = hr_nxt;
        if (!day_cy)
            nxt.dow = now_q.dow;
        else if (now_q.dow >= 8'd7 || now_q.dow == 8'd0)
            nxt.dow = 8'd1;
        else
            nxt.dow = now_q.dow + 8'd1;
    end

    tod_alarm_match #(.FIELDS(3)) u_match (
        .now_i ({nxt.hr, nxt.min, nxt.sec}),
        .alm_i ({ahr_q, amin_q, asec_q}),
        .hit_o (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '{hold: 1'b0, binary: 1'b0, hr24: 1'b1};
            now_q  <= '{sec: 8'h00, min: 8'h00, hr: 8'h00, dow: 8'h01};
            asec_q <= '0;
            amin_q <= '0;
            ahr_q  <= '0;
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (accept)
                cnt_q <= CNT_W'(UIP_CYCLES);
            else if (uip)
                cnt_q <= cnt_q - CNT_W'(1);

            if (commit) begin
                now_q <= nxt;
                if (hit) flag_q <= 1'b1;
            end

            if (bus_we) begin
                case (int'(bus_addr))
                    A_SEC:  now_q.sec <= bus_wdata & field_mask(F_SEC, mode_q);
                    A_MIN:  now_q.min <= bus_wdata & field_mask(F_MIN, mode_q);
                    A_HR:   now_q.hr  <= bus_wdata & field_mask(F_HR, mode_q);
                    A_DOW:  now_q.dow <= bus_wdata & field_mask(F_DOW, mode_q);
                    A_ASEC: asec_q    <= bus_wdata;
                    A_AMIN: amin_q    <= bus_wdata;
                    A_AHR:  ahr_q     <= bus_wdata;
                    A_CTRL: mode_q    <= '{hold:   bus_wdata[CTRL_HOLD_BIT],
                                           binary: bus_wdata[CTRL_BIN_BIT],
                                           hr24:   bus_wdata[CTRL_H24_BIT]};
                    A_ALST: flag_q    <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        case (int'(bus_addr))
            A_SEC:  bus_rdata = now_q.sec;
            A_ASEC: bus_rdata = asec_q;
            A_MIN:  bus_rdata = now_q.min;
            A_AMIN: bus_rdata = amin_q;
            A_HR:   bus_rdata = now_q.hr;
            A_AHR:  bus_rdata = ahr_q;
            A_DOW:  bus_rdata = now_q.dow;
            A_STAT: bus_rdata[7] = uip;
            A_CTRL: begin
                bus_rdata[CTRL_HOLD_BIT] = mode_q.hold;
                bus_rdata[CTRL_BIN_BIT]  = mode_q.binary;
                bus_rdata[CTRL_H24_BIT]  = mode_q.hr24;
            end
            A_ALST: bus_rdata[7] = flag_q;
            default: ;
        endcase
    end

    assign alarm_flag  = flag_q;
    assign update_busy = uip;

    // R8: outside the busy window only a write can move the seconds
    assert_quiet_outside_window_R8: assert property (@(posedge clk) disable iff (rst)
        (!uip && !(bus_we && int'(bus_addr) == A_SEC)) |=> $stable(now_q.sec));

    // R8: window counter never exceeds its length
    assert_window_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(UIP_CYCLES));

    // R7: hold freezes the minutes apart from writes
    assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q.hold && !(bus_we && int'(bus_addr) == A_MIN)) |=> $stable(now_q.min));

    // R10: the flag only rises at the end of an update window
    assert_flag_from_update_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(uip));

endmodule

// File: tb/tod_clock_tb.sv
module tod_clock_tb;
    localparam int UIPC = 3;
    localparam int AW   = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_1hz = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          alarm_flag, update_busy;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tod_clock #(.ADDR_W(AW), .UIP_CYCLES(UIPC)) u_dut (
        .clk, .rst, .tick_1hz, .bus_we, .bus_addr, .bus_wdata,
        .bus_rdata, .alarm_flag, .update_busy
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        bus_addr = AW'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic do_tick();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        repeat (UIPC) @(negedge clk);
    endtask

    function automatic int enc(input int n, input bit bin);
        return bin ? n : ((n / 10) << 4) | (n % 10);
    endfunction

    function automatic int hr_byte(input int h, input bit bin, input bit h24);
        int h12;
        if (h24) return enc(h, bin);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return (h >= 12 ? 'h80 : 0) | enc(h12, bin);
    endfunction

    task automatic load_time(input int t, input int day, input bit bin, input bit h24);
        wr('h0, enc(t % 60, bin));
        wr('h2, enc((t / 60) % 60, bin));
        wr('h4, hr_byte(t / 3600, bin, h24));
        wr('h6, day);
    endtask

    task automatic check_time(input int t, input int day, input bit bin, input bit h24);
        int v;
        rd('h0, v); chk("R3", "seconds", v, enc(t % 60, bin));
        rd('h2, v); chk("R3", "minutes", v, enc((t / 60) % 60, bin));
        rd('h4, v); chk(h24 ? "R4" : "R5", "hours", v, hr_byte(t / 3600, bin, h24));
        rd('h6, v); chk("R6", "day", v, day);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(a, v); chk("R1", "reset field", v, 0);
        end
        rd('h6, v); chk("R1", "reset day", v, 1);
        rd('hB, v); chk("R1", "reset control", v, 'h02);
        rd('hA, v); chk("R1", "reset status", v, 0);
        rd('hC, v); chk("R1", "reset alarm status", v, 0);
        chk("R1", "reset flags", {alarm_flag, update_busy}, 0);

        // R2 masking per mode
        wr('h0, 'hFF); rd('h0, v); chk("R2", "sec mask bcd", v, 'h7F);
        wr('h4, 'hFF); rd('h4, v); chk("R2", "hr mask bcd24", v, 'h3F);
        wr('h6, 'hFF); rd('h6, v); chk("R2", "day mask", v, 'h07);
        wr('h1, 'hFF); rd('h1, v); chk("R2", "alarm whole byte", v, 'hFF);
        wr('hB, 'h06); wr('h4, 'hFF); rd('h4, v); chk("R2", "hr mask bin24", v, 'h1F);
        wr('h2, 'hFF); rd('h2, v); chk("R2", "min mask bin", v, 'h3F);
        wr('hB, 'h04); wr('h4, 'hFF); rd('h4, v); chk("R2", "hr mask bin12", v, 'h8F);
        wr('hB, 'h00); wr('h4, 'hFF); rd('h4, v); chk("R2", "hr mask bcd12", v, 'h9F);
        rd('hB, v); chk("R2", "control readback", v, 'h00);

        // R8 busy window
        wr('hB, 'h02); wr('h0, 'h20);
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        rd('hA, v); chk("R8", "status busy at start", v, 'h80);
        rd('h0, v); chk("R8", "sec held at start", v, 'h20);
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        chk("R8", "busy port at end", update_busy, 1);
        rd('h0, v); chk("R8", "sec held at end", v, 'h20);
        @(negedge clk);
        chk("R8", "busy port cleared", update_busy, 0);
        rd('h0, v); chk("R8", "sec after window", v, 'h21);
        repeat (6) @(negedge clk);
        rd('h0, v); chk("R8", "extra tick dropped", v, 'h21);

        // R3..R6 sweep every hour boundary in every format
        for (int m = 0; m < 4; m++) begin
            bit bin, h24;
            bin = m[0]; h24 = m[1];
            wr('hB, (bin ? 4 : 0) | (h24 ? 2 : 0));
            for (int h = 0; h < 24; h++) begin
                int t, day;
                t = h * 3600 + 59 * 60 + 58;
                day = (h == 23) ? 7 : (h % 7) + 1;
                load_time(t, day, bin, h24);
                for (int k = 0; k < 3; k++) begin
                    do_tick();
                    t++;
                    if (t == 86400) begin
                        t = 0;
                        day = (day == 7) ? 1 : day + 1;
                    end
                    check_time(t, day, bin, h24);
                end
            end
            // R3 seconds and minutes sweep from midnight
            begin
                int t;
                load_time(0, 1, bin, h24);
                t = 0;
                for (int k = 0; k < 125; k++) begin
                    do_tick();
                    t++;
                    rd('h0, v); chk("R3", "sweep seconds", v, enc(t % 60, bin));
                    rd('h2, v); chk("R3", "sweep minutes", v, enc(t / 60, bin));
                end
            end
        end

        // R7 hold bit
        wr('hB, 'h82); wr('h0, 'h15);
        do_tick();
        rd('h0, v); chk("R7", "held seconds", v, 'h15);
        chk("R7", "no busy while held", update_busy, 0);
        wr('h0, 'h30); rd('h0, v); chk("R7", "write while held", v, 'h30);
        wr('hB, 'h02);
        do_tick();
        rd('h0, v); chk("R7", "runs after release", v, 'h31);

        // R9 exact alarm
        wr('hC, 0);
        wr('h1, 'h10); wr('h3, 'h00); wr('h5, 'h05);
        load_time(5 * 3600 + 8, 1, 1'b0, 1'b1);
        do_tick();
        chk("R9", "no flag before match", alarm_flag, 0);
        do_tick();
        chk("R9", "flag on match", alarm_flag, 1);
        rd('hC, v); chk("R9", "alarm status bit", v, 'h80);
        wr('hC, 0);
        chk("R9", "flag cleared", alarm_flag, 0);
        do_tick();
        chk("R9", "no flag after match passes", alarm_flag, 0);

        // R10 write-made match
        wr('h0, 'h10);
        repeat (2) @(negedge clk);
        chk("R10", "write match no flag", alarm_flag, 0);

        // R9 wildcard alarm bytes
        wr('h1, 'hC0); wr('h3, 'hFF); wr('h5, 'h06);
        load_time(5 * 3600 + 59 * 60 + 59, 1, 1'b0, 1'b1);
        do_tick();
        chk("R9", "wildcard match at 06:00:00", alarm_flag, 1);
        wr('hC, 0);
        do_tick();
        chk("R9", "wildcard match at 06:00:01", alarm_flag, 1);
        wr('hC, 0); wr('h5, 'h07);
        do_tick();
        chk("R9", "hour mismatch no flag", alarm_flag, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule